// File: doc/BRIEF.md
# Strobe-Triggered Memory Write Master

This block takes 32-bit samples that arrive alongside a slow strobe from another clock domain and stores each sample as one word in memory through a simple memory-mapped write master port. The strobe is brought into the fast system clock through a chain of synchronizing flops. Only its synchronized rising edge counts, so a strobe held high for many system cycles still produces a single write.

Each rising edge copies the sample input into a one-word holding register. The block then asserts a write request with that word and the current byte address. The request stays asserted until the slave drops its wait-request signal. The address starts at a base value set by a parameter and steps by one word (four bytes) after each accepted write. If another edge arrives while a write is still outstanding, the block does not start a second write. Instead it raises an overflow flag that stays set until reset.

Top module: `strobe_write_master`

## Requirements
- R1: While the synchronous reset is high, and in the cycle after it, the write request is low, the overflow flag is low and the address output equals the base address parameter (default 0x0000_1000).
- R2: Each rising edge of the strobe produces exactly one accepted write, whether the strobe stays high for 2 or for 40 system cycles. A strobe that stays low produces no write.
- R3: A strobe edge that arrives while a write is pending starts no second write. It sets the overflow flag, and the flag stays high until reset.
- R4: While the write request is high and wait-request is high, the request stays high and the address and write data do not change.
- R5: After every accepted write (write high and wait-request low at a clock edge) the address grows by 4. At all other times it holds. The n-th write after reset therefore goes to base + 4*n.
- R6: The write data of each write equals the sample input present at that write's strobe rising edge.
- R7: After an accepted write the request drops in the next cycle, so each accepted transfer carries exactly one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_i | input | 1 | Slow strobe from another clock domain; a rising edge marks a new sample |
| sample_i | input | 32 | Sample word, stable around the strobe edge |
| mem_addr_o | output | 32 | Byte address of the current write |
| mem_wdata_o | output | 32 | Write data (held sample) |
| mem_write_o | output | 1 | Write request |
| mem_waitreq_i | input | 1 | Slave stall; the write is accepted in a cycle where it is low |
| overflow_o | output | 1 | Sticky flag: a strobe edge arrived during a pending write |

## Verification
The assertions check on every cycle that the reset values are right, that address and data stay stable while the slave stalls, that the address steps by four only on an accepted write, that the request falls after acceptance, and that the overflow flag is sticky. Some behaviour spans the whole path from the strobe pin to memory: one write per edge for any high time, the data captured at that edge, and a second edge during a long stall being dropped rather than queued. Only the bench's scenarios show these, because they track each strobe against the transfers a memory model records.

// File: rtl/wm_pkg.sv
`timescale 1ns/1ps
package wm_pkg;
    typedef enum logic {
        WM_IDLE = 1'b0,
        WM_BUSY = 1'b1
    } wm_state_e;
endpackage

// File: rtl/wm_sync_edge.sv
`timescale 1ns/1ps
// Multi-flop synchronizer followed by a rising-edge detector.
module wm_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
        if (gi == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain_q[gi] <= 1'b0;
                else     chain_q[gi] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain_q[gi] <= 1'b0;
                else     chain_q[gi] <= chain_q[gi-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/wm_addr_gen.sv
`timescale 1ns/1ps
// Word address counter: starts at BASE, advances one word per accepted write.
module wm_addr_gen #(
    parameter int              ADDR_W = 32,
    parameter int              DATA_W = 32,
    parameter logic [ADDR_W-1:0] BASE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (adv_i) addr_d = addr_q + STEP;
    end

    always_ff @(posedge clk) begin
        if (rst) addr_q <= BASE;
        else     addr_q <= addr_d;
    end

    assign addr_o = addr_q;
endmodule

// File: rtl/wm_write_fsm.sv
`timescale 1ns/1ps
// Holding register, write handshake and sticky overflow.
module wm_write_fsm
    import wm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              waitreq_i,
    output logic              write_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              overflow_o,
    output logic              accept_o
);
    typedef struct packed {
        wm_state_e         state;
        logic              ovf;
        logic [DATA_W-1:0] hold;
    } fsm_t;

    fsm_t st_d, st_q;
    logic accept;

    always_comb begin
        st_d   = st_q;
        accept = (st_q.state == WM_BUSY) && !waitreq_i;
        if (accept) st_d.state = WM_IDLE;
        if (rise_i) begin
            if (st_q.state == WM_BUSY) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.state = WM_BUSY;
                st_d.hold  = data_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.state <= WM_IDLE;
            st_q.ovf   <= 1'b0;
            st_q.hold  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign write_o    = (st_q.state == WM_BUSY);
    assign wdata_o    = st_q.hold;
    assign overflow_o = st_q.ovf;
    assign accept_o   = accept;
endmodule

// File: rtl/strobe_write_master.sv
`timescale 1ns/1ps
module strobe_write_master #(
    parameter int                ADDR_W      = 32,
    parameter int                DATA_W      = 32,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_write_o,
    input  logic              mem_waitreq_i,
    output logic              overflow_o
);
    logic rise;
    logic accept;

    wm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (strobe_i),
        .rise_o  (rise)
    );

    wm_write_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .rise_i     (rise),
        .data_i     (sample_i),
        .waitreq_i  (mem_waitreq_i),
        .write_o    (mem_write_o),
        .wdata_o    (mem_wdata_o),
        .overflow_o (overflow_o),
        .accept_o   (accept)
    );

    wm_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE_ADDR)) u_addr (
        .clk    (clk),
        .rst    (rst),
        .adv_i  (accept),
        .addr_o (mem_addr_o)
    );
endmodule

// File: rtl/wm_checker.sv
`timescale 1ns/1ps
module wm_checker #(
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              write,
    input logic              waitreq,
    input logic              ovf
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!write && !ovf && addr == BASE_ADDR));

    p_stall_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (write && waitreq) |=> (write && $stable(addr) && $stable(wdata)));

    p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
        (write && !waitreq) |=> (addr == $past(addr) + STEP));

    p_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !(write && !waitreq) |=> $stable(addr));

    p_single_word_r7: assert property (@(posedge clk) disable iff (rst)
        (write && !waitreq) |=> !write);

    p_no_overflow_clear_r3: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);
endmodule

bind strobe_write_master wm_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)
) u_wm_checker (
    .clk     (clk),
    .rst     (rst),
    .addr    (mem_addr_o),
    .wdata   (mem_wdata_o),
    .write   (mem_write_o),
    .waitreq (mem_waitreq_i),
    .ovf     (overflow_o)
);

// File: tb/test_strobe_write_master.sv
`timescale 1ns/1ps
module test_strobe_write_master;
    localparam logic [31:0] BASE = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strobe = 1'b0;
    logic [31:0] sample = '0;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_write;
    logic        waitreq = 1'b0;
    logic        overflow;

    int n_checks = 0;
    int n_errors = 0;
    bit force_stall = 1'b0;
    int stall_run = 0;

    logic [31:0] exp_data [0:255];
    int exp_cnt = 0;
    int wr_cnt = 0;
    int seg_start = 0;

    bit          prev_pend = 1'b0;
    logic [31:0] prev_addr, prev_data;

    always #2.5 clk = ~clk;

    strobe_write_master i_strobe_write_master (
        .clk           (clk),
        .rst           (rst),
        .strobe_i      (strobe),
        .sample_i      (sample),
        .mem_addr_o    (mem_addr),
        .mem_wdata_o   (mem_wdata),
        .mem_write_o   (mem_write),
        .mem_waitreq_i (waitreq),
        .overflow_o    (overflow)
    );

    function automatic logic [31:0] exp_addr(int idx);
        return BASE + 32'(4 * (idx - seg_start));
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, expv);
        end
    endtask

    // Slave model: decides stall at negedge, records accepted words.
    always @(negedge clk) begin
        if (force_stall)        waitreq = 1'b1;
        else if (stall_run >= 3) waitreq = 1'b0;
        else                    waitreq = (($urandom % 10) < 4);
        stall_run = waitreq ? stall_run + 1 : 0;

        if (!rst && prev_pend) begin
            chk(mem_write == 1'b1, "R4 write held", 32'(mem_write), 32'd1);
            chk(mem_addr == prev_addr, "R4 addr stable", mem_addr, prev_addr);
            chk(mem_wdata == prev_data, "R4 data stable", mem_wdata, prev_data);
        end
        if (!rst && mem_write && !waitreq) begin
            chk(wr_cnt < exp_cnt, "R2 unexpected write", 32'(wr_cnt), 32'(exp_cnt));
            if (wr_cnt < exp_cnt) begin
                chk(mem_wdata == exp_data[wr_cnt], "R6 data", mem_wdata, exp_data[wr_cnt]);
                chk(mem_addr == exp_addr(wr_cnt), "R5 address", mem_addr, exp_addr(wr_cnt));
            end
            wr_cnt++;
        end
        prev_pend = !rst && mem_write && waitreq;
        prev_addr = mem_addr;
        prev_data = mem_wdata;
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(int high, int period, logic [31:0] d, bit expect_write);
        sample = d;
        strobe = 1'b1;
        if (expect_write) begin
            exp_data[exp_cnt] = d;
            exp_cnt++;
        end
        cycles(high);
        strobe = 1'b0;
        cycles(period - high);
    endtask

    initial begin
        void'($urandom(32'd1234));
        cycles(3);
        // R1: reset values
        chk(mem_write == 1'b0, "R1 write", 32'(mem_write), 32'd0);
        chk(overflow == 1'b0, "R1 overflow", 32'(overflow), 32'd0);
        chk(mem_addr == BASE, "R1 address", mem_addr, BASE);
        rst = 1'b0;

        // R2: idle strobe gives no write
        cycles(20);
        chk(wr_cnt == 0, "R2 idle", 32'(wr_cnt), 32'd0);

        // R2/R5/R6: random high times, random stalls
        for (int i = 0; i < 40; i++) begin
            int h;
            h = 2 + int'($urandom % 7);
            pulse(h, 10, $urandom, 1'b1);
        end
        cycles(8);
        chk(wr_cnt == exp_cnt, "R2 count random", 32'(wr_cnt), 32'(exp_cnt));
        chk(overflow == 1'b0, "R3 no overflow", 32'(overflow), 32'd0);

        // R2: very long high time, one write
        pulse(40, 50, 32'hA5A5_0001, 1'b1);
        chk(wr_cnt == exp_cnt, "R2 long high", 32'(wr_cnt), 32'(exp_cnt));

        // R2: minimum high time
        pulse(2, 10, 32'h0000_0002, 1'b1);
        cycles(6);
        chk(wr_cnt == exp_cnt, "R2 short high", 32'(wr_cnt), 32'(exp_cnt));

        // R3: second edge during a long stall
        force_stall = 1'b1;
        pulse(3, 10, 32'hCAFE_0001, 1'b1);
        pulse(3, 10, 32'hCAFE_0002, 1'b0);
        cycles(3);
        chk(overflow == 1'b1, "R3 overflow set", 32'(overflow), 32'd1);
        chk(mem_wdata == 32'hCAFE_0001, "R3 first word kept", mem_wdata, 32'hCAFE_0001);
        chk(mem_write == 1'b1, "R4 still requesting", 32'(mem_write), 32'd1);
        force_stall = 1'b0;
        cycles(8);
        chk(wr_cnt == exp_cnt, "R3 one write only", 32'(wr_cnt), 32'(exp_cnt));
        chk(mem_write == 1'b0, "R7 request dropped", 32'(mem_write), 32'd0);

        // R3: flag stays set through later normal writes
        for (int i = 0; i < 5; i++) pulse(4, 10, $urandom, 1'b1);
        cycles(6);
        chk(overflow == 1'b1, "R3 sticky", 32'(overflow), 32'd1);
        chk(wr_cnt == exp_cnt, "R2 count after overflow", 32'(wr_cnt), 32'(exp_cnt));

        // R1: reset in operation clears flag and address
        rst = 1'b1;
        cycles(2);
        seg_start = wr_cnt;
        chk(overflow == 1'b0, "R1 overflow cleared", 32'(overflow), 32'd0);
        chk(mem_addr == BASE, "R1 address restored", mem_addr, BASE);
        chk(mem_write == 1'b0, "R1 write low", 32'(mem_write), 32'd0);
        rst = 1'b0;
        cycles(2);

        // R5: addresses restart from base
        for (int i = 0; i < 6; i++) pulse(2 + i, 10, $urandom, 1'b1);
        cycles(8);
        chk(wr_cnt == exp_cnt, "R5 count after reset", 32'(wr_cnt), 32'(exp_cnt));
        chk(mem_addr == BASE + 32'd24, "R5 final address", mem_addr, BASE + 32'd24);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #500000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule